// File: doc/BRIEF.md
# Two-Level Translation Walker

This block resolves a missed address translation by walking a two-level page table held in memory. A 32-bit virtual address is taken in on a valid/ready request and split into three fields:

- a 10-bit outer index in bits 31:22,
- a 10-bit inner index in bits 21:12,
- a 12-bit page offset in bits 11:0.

The outer index is first compared with a table-length input. If it is in range, the block reads the outer entry at the table base plus four times the outer index. The frame in that entry locates one piece of the inner table, and a second read fetches the inner entry. The block then reports the data frame, its writable flag and the full physical address. If the length check or either entry fails, it reports a fault code instead.

Every table entry is one 32-bit word laid out as follows:

- bits 31:12 hold a frame number,
- bit 1 is a writable flag,
- bit 0 is a valid flag.

Memory is reached through a single read port with a request handshake and a response strobe. The response may arrive any number of cycles after the request is accepted. Only one walk is in flight at a time, and the result is a one-cycle strobe, so it can be installed directly into a translation buffer by the caller.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held, req_ready is 1, and mem_req_valid and rsp_valid are 0.
- R2: The first memory read of an in-range walk uses the address tbl_base + 4 × vaddr[31:22].
- R3: If vaddr[31:22] is greater than or equal to tbl_len when the request is accepted, no memory read is issued. rsp_valid rises in the cycle after acceptance with fault code 1.
- R4: After a valid outer entry E, the second read uses the address {E[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: An outer entry with bit 0 clear ends the walk with fault code 2, and no second read is issued.
- R6: An inner entry with bit 0 clear ends the walk with fault code 3.
- R7: For a valid inner entry I, the result has fault code 0, rsp_fault = 0, rsp_frame = I[31:12], rsp_writable = I[1] and rsp_paddr = {I[31:12], vaddr[11:0]}.
- R8: mem_req_valid stays high, with mem_req_addr unchanged, until a cycle in which mem_req_ready is 1.
- R9: req_ready is 1 only while no walk is in progress and no result is being presented. A request offered at any other time is not taken.
- R10: rsp_valid lasts exactly one cycle per walk. On any fault, rsp_fault = 1 and rsp_frame, rsp_writable and rsp_paddr are all 0.
- R11: A memory response strobe that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical address of the outer table |
| tbl_len | input | 11 | Number of outer entries in use |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word read |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_code | output | 2 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_frame | output | 20 | Data frame number |
| rsp_writable | output | 1 | Writable flag of the inner entry |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
Result delivery and the arrival of the next request share a cycle whenever requests are queued back to back. The bench therefore holds req_valid high through every result strobe and judges, clock by clock, that the request is taken only in the cycle after the strobe ends.

A second overlap is a memory response strobe that coincides with a pending read request or with the result cycle. The bench injects stray strobes with random data whenever its memory model has no read outstanding. It then confirms that the walk sequence and the reported result stay exactly as its behavioural model predicts.

// File: rtl/xw_pkg.sv
// Shared types for the translation walker.
// Assumes entries are one word with flags in the low bits.
package xw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_OUT  = 3'd1,
        ST_WT_OUT  = 3'd2,
        ST_RD_IN   = 3'd3,
        ST_WT_IN   = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_RANGE = 2'd1,
        FLT_OUTER = 2'd2,
        FLT_INNER = 2'd3
    } walk_fault_t;

    localparam int unsigned ENT_VALID_BIT = 0;
    localparam int unsigned ENT_WRITE_BIT = 1;

endpackage

// File: rtl/xw_va_split.sv
// Splits a virtual address into outer index, inner index and offset,
// and flags an outer index at or past the table length.
// Assumes the address width equals the sum of the three field widths.
module xw_va_split #(
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int OFF_W = 12,
    localparam int VA_W  = OUT_W + IN_W + OFF_W,
    localparam int LEN_W = OUT_W + 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LEN_W-1:0] tbl_len,
    output logic [OUT_W-1:0] outer_idx,
    output logic [IN_W-1:0]  inner_idx,
    output logic [OFF_W-1:0] offset,
    output logic             out_of_range
);

    // Field extraction and length comparison.
    always_comb begin
        outer_idx    = vaddr[VA_W-1 -: OUT_W];
        inner_idx    = vaddr[OFF_W +: IN_W];
        offset       = vaddr[OFF_W-1:0];
        out_of_range = ({1'b0, outer_idx} >= tbl_len);
    end

endmodule

// File: rtl/xw_ent_addr.sv
// Forms the byte address of a table entry: table base plus four
// times the index. Assumes 4-byte entries and a wrapping sum.
module xw_ent_addr #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);

    localparam int PAD_W = PA_W - IDX_W - 2;

    // Scaled index added to the base.
    always_comb begin
        addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
    end

endmodule

// File: rtl/xw_walk_fsm.sv
// Sequencer for the two-step table walk. It latches the request fields
// on acceptance, issues the outer read and then the inner read, holds
// each read until it is accepted, and presents the result for one cycle.
// Assumes a response only arrives for a read that has been accepted.
module xw_walk_fsm
    import xw_pkg::*;
#(
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               out_of_range,
    input  logic [OUT_W-1:0]   in_outer,
    input  logic [IN_W-1:0]    in_inner,
    input  logic [OFF_W-1:0]   in_offset,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic               mem_req_valid,
    output logic               sel_inner,
    output logic [OUT_W-1:0]   outer_idx,
    output logic [IN_W-1:0]    inner_idx,
    output logic [FRAME_W-1:0] inner_frame,
    output logic               rsp_valid,
    output walk_fault_t        rsp_code,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic               rsp_writable,
    output logic [OFF_W-1:0]   rsp_offset
);

    walk_state_t state_q, state_d;
    logic        accept;
    logic        ent_valid;
    logic        ent_write;
    logic        unused_ent_bits;

    assign ent_valid       = mem_rsp_data[ENT_VALID_BIT];
    assign ent_write       = mem_rsp_data[ENT_WRITE_BIT];
    assign unused_ent_bits = ^mem_rsp_data[OFF_W-1:2];

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign mem_req_valid = (state_q == ST_RD_OUT) || (state_q == ST_RD_IN);
    assign sel_inner     = (state_q == ST_RD_IN);
    assign rsp_valid     = (state_q == ST_DONE);

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = out_of_range ? ST_DONE : ST_RD_OUT;
            ST_RD_OUT: if (mem_req_ready) state_d = ST_WT_OUT;
            ST_WT_OUT: if (mem_rsp_valid) state_d = ent_valid ? ST_RD_IN : ST_DONE;
            ST_RD_IN:  if (mem_req_ready) state_d = ST_WT_IN;
            ST_WT_IN:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request field capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_idx  <= '0;
            inner_idx  <= '0;
            rsp_offset <= '0;
        end else if (accept) begin
            outer_idx  <= in_outer;
            inner_idx  <= in_inner;
            rsp_offset <= in_offset;
        end
    end

    // Inner table frame from a valid outer entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_frame <= '0;
        end else if (state_q == ST_WT_OUT && mem_rsp_valid && ent_valid) begin
            inner_frame <= mem_rsp_data[PA_W-1:OFF_W];
        end
    end

    // Result and fault code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_code     <= FLT_NONE;
            rsp_frame    <= '0;
            rsp_writable <= 1'b0;
        end else if (accept) begin
            rsp_code     <= out_of_range ? FLT_RANGE : FLT_NONE;
            rsp_frame    <= '0;
            rsp_writable <= 1'b0;
        end else if (state_q == ST_WT_OUT && mem_rsp_valid && !ent_valid) begin
            rsp_code <= FLT_OUTER;
        end else if (state_q == ST_WT_IN && mem_rsp_valid) begin
            if (ent_valid) begin
                rsp_frame    <= mem_rsp_data[PA_W-1:OFF_W];
                rsp_writable <= ent_write;
            end else begin
                rsp_code <= FLT_INNER;
            end
        end
    end

    // R8: an unaccepted read stays requested.
    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid);

    // R3: an out-of-range request goes straight to the result.
    a_r3_range_skips_memory: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && out_of_range |=> rsp_valid && !mem_req_valid);

    // R10: the result strobe lasts one cycle.
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/xlat_walker.sv
// Top of the two-level translation walker. It splits the incoming
// address, forms the outer and inner entry addresses, and lets the
// sequencer drive the memory port and the result.
// Assumes tbl_base and tbl_len are held steady while a walk runs.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int OUT_W = 10,
    parameter int IN_W  = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    localparam int VA_W    = OUT_W + IN_W + OFF_W,
    localparam int LEN_W   = OUT_W + 1,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PA_W-1:0]    tbl_base,
    input  logic [LEN_W-1:0]   tbl_len,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_fault_code,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic               rsp_writable,
    output logic [PA_W-1:0]    rsp_paddr
);

    logic [OUT_W-1:0]   live_outer, held_outer;
    logic [IN_W-1:0]    live_inner, held_inner;
    logic [OFF_W-1:0]   live_offset, held_offset;
    logic               live_oor;
    logic               sel_inner;
    logic [FRAME_W-1:0] inner_frame;
    logic [PA_W-1:0]    outer_addr, inner_addr;
    walk_fault_t        code;

    xw_va_split #(.OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W)) u_split (
        .vaddr        (req_vaddr),
        .tbl_len      (tbl_len),
        .outer_idx    (live_outer),
        .inner_idx    (live_inner),
        .offset       (live_offset),
        .out_of_range (live_oor)
    );

    xw_ent_addr #(.PA_W(PA_W), .IDX_W(OUT_W)) u_outer_addr (
        .base (tbl_base),
        .idx  (held_outer),
        .addr (outer_addr)
    );

    xw_ent_addr #(.PA_W(PA_W), .IDX_W(IN_W)) u_inner_addr (
        .base ({inner_frame, {OFF_W{1'b0}}}),
        .idx  (held_inner),
        .addr (inner_addr)
    );

    xw_walk_fsm #(.OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .out_of_range  (live_oor),
        .in_outer      (live_outer),
        .in_inner      (live_inner),
        .in_offset     (live_offset),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .sel_inner     (sel_inner),
        .outer_idx     (held_outer),
        .inner_idx     (held_inner),
        .inner_frame   (inner_frame),
        .rsp_valid     (rsp_valid),
        .rsp_code      (code),
        .rsp_frame     (rsp_frame),
        .rsp_writable  (rsp_writable),
        .rsp_offset    (held_offset)
    );

    // Read address and result formatting.
    always_comb begin
        mem_req_addr   = sel_inner ? inner_addr : outer_addr;
        rsp_fault_code = code;
        rsp_fault      = (code != FLT_NONE);
        rsp_paddr      = (code == FLT_NONE) ? {rsp_frame, held_offset} : '0;
    end

    // R8: the read address does not move while the read waits.
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

    // R9: taking a request excludes memory traffic and result delivery.
    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid);

    // R10: a faulted result carries no translation.
    a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_frame == '0 && !rsp_writable && rsp_paddr == '0);

endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] tbl_base = 32'h0040_0000;
    logic [10:0] tbl_len = 11'd8;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;
    logic [19:0] rsp_frame;
    logic        rsp_writable;
    logic [31:0] rsp_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .tbl_base(tbl_base), .tbl_len(tbl_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
        .rsp_frame(rsp_frame), .rsp_writable(rsp_writable), .rsp_paddr(rsp_paddr)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] va_q[$];

    // flags captured at the falling edge for the driver
    bit          acc_req = 0;
    bit          acc_mem = 0;
    logic [31:0] acc_mem_addr = '0;
    bit          stray = 0;

    // memory responder state
    bit          rd_out = 0;
    logic [31:0] rd_addr = '0;
    int          lat = 0;

    // reference model: 0 idle, 1 read wanted, 2 awaiting data, 3 result
    int          ph = 0;
    int          stage = 0;
    logic [31:0] m_va = '0;
    logic [31:0] exp_addr = '0;
    logic [1:0]  exp_code = '0;
    logic [19:0] exp_frame = '0;
    logic        exp_wr = 1'b0;
    logic [31:0] exp_paddr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic string code_tag(input logic [1:0] c);
        case (c)
            2'd1:    return "R3";
            2'd2:    return "R5";
            2'd3:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // Monitor and behavioural model, evaluated mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", "req_ready", 32'(req_ready), 32'(ph == 0));
            chk("R8", "mem_req_valid", 32'(mem_req_valid), 32'(ph == 1));
            if (ph == 1)
                chk(stage == 0 ? "R2" : "R4", "mem_req_addr", mem_req_addr, exp_addr);
            chk("R10", "rsp_valid", 32'(rsp_valid), 32'(ph == 3));
            if (ph == 3) begin
                chk(code_tag(exp_code), "fault_code", 32'(rsp_fault_code), 32'(exp_code));
                chk(code_tag(exp_code), "fault", 32'(rsp_fault), 32'(exp_code != 0));
                chk(exp_code != 0 ? "R10" : "R7", "frame", 32'(rsp_frame), 32'(exp_frame));
                chk(exp_code != 0 ? "R10" : "R7", "writable", 32'(rsp_writable), 32'(exp_wr));
                chk(exp_code != 0 ? "R10" : "R7", "paddr", rsp_paddr, exp_paddr);
            end
            if (stray)
                chk("R11", "state after stray strobe",
                    {30'd0, mem_req_valid, rsp_valid}, {30'd0, 1'(ph == 1), 1'(ph == 3)});

            acc_req      = req_valid && req_ready;
            acc_mem      = mem_req_valid && mem_req_ready;
            acc_mem_addr = mem_req_addr;

            case (ph)
                0: if (req_valid) begin
                    m_va      = req_vaddr;
                    exp_frame = '0;
                    exp_wr    = 1'b0;
                    exp_paddr = '0;
                    if ({1'b0, m_va[31:22]} >= tbl_len) begin
                        exp_code = 2'd1;
                        ph = 3;
                    end else begin
                        exp_code = 2'd0;
                        stage    = 0;
                        exp_addr = tbl_base + 32'(m_va[31:22]) * 4;
                        ph = 1;
                    end
                end
                1: if (mem_req_ready) ph = 2;
                2: if (mem_rsp_valid) begin
                    if (stage == 0) begin
                        if (!mem_rsp_data[0]) begin
                            exp_code = 2'd2;
                            ph = 3;
                        end else begin
                            exp_addr = {mem_rsp_data[31:12], 12'h000} + 32'(m_va[21:12]) * 4;
                            stage = 1;
                            ph = 1;
                        end
                    end else begin
                        if (!mem_rsp_data[0]) begin
                            exp_code = 2'd3;
                        end else begin
                            exp_frame = mem_rsp_data[31:12];
                            exp_wr    = mem_rsp_data[1];
                            exp_paddr = {mem_rsp_data[31:12], m_va[11:0]};
                        end
                        ph = 3;
                    end
                end
                default: ph = 0;
            endcase
        end
    end

    // Input driver: requests, memory acceptance and responses.
    always @(posedge clk) begin
        #1;
        if (acc_req) void'(va_q.pop_front());
        acc_req = 0;
        if (va_q.size() > 0 && ($urandom % 6) != 0) begin
            req_valid = 1'b1;
            req_vaddr = va_q[0];
        end else begin
            req_valid = 1'b0;
        end
        mem_rsp_valid = 1'b0;
        stray = 0;
        if (acc_mem) begin
            rd_out  = 1;
            rd_addr = acc_mem_addr;
            lat     = $urandom % 3;
        end else if (rd_out && lat > 0) begin
            lat--;
        end
        acc_mem = 0;
        if (rd_out && lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(rd_addr);
            rd_out = 0;
        end else if (!rd_out && rst_n && ($urandom % 5) == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = $urandom;
            stray = 1;
        end
        mem_req_ready = ($urandom % 3) != 0;
    end

    function automatic logic [31:0] va(input int o, input int i, input int off);
        return {o[9:0], i[9:0], off[11:0]};
    endfunction

    task automatic drain();
        wait (va_q.size() == 0 && ph == 0);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        // outer table at 0x0040_0000
        mem[32'h0040_0000] = 32'h0050_0001;
        mem[32'h0040_000C] = 32'h0060_0003;
        mem[32'h0040_0014] = 32'h0070_0002;
        mem[32'h0040_001C] = 32'h0080_0001;
        mem[32'h0040_0FFC] = 32'h0090_0001;
        // inner tables
        mem[32'h0050_0000] = 32'h1234_5003;
        mem[32'h0050_0004] = 32'hABCD_E001;
        mem[32'h0050_0008] = 32'h0000_0002;
        mem[32'h0050_0FFC] = 32'hFFFF_F003;
        mem[32'h0060_0014] = 32'h0BEE_F001;
        mem[32'h0080_0000] = 32'h0004_2003;
        mem[32'h0090_0FFC] = 32'h7777_7001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "req_ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int rep = 0; rep < 3; rep++) begin
            va_q.push_back(va(0, 0, 12'h123));     // R7 writable
            va_q.push_back(va(0, 1, 12'hFFF));     // R7 read-only
            va_q.push_back(va(0, 2, 0));           // R6
            va_q.push_back(va(0, 1023, 12'h456));  // R4 top inner index
            va_q.push_back(va(3, 5, 1));
            va_q.push_back(va(5, 0, 0));           // R5
            va_q.push_back(va(7, 0, 12'hABC));     // last in-range index
            va_q.push_back(va(8, 0, 0));           // R3 at the limit
            va_q.push_back(va(3, 6, 0));           // R6 empty word
            va_q.push_back(va(1023, 1023, 0));     // R3 far beyond
            va_q.push_back(va(1, 0, 0));           // R5 empty word
        end
        drain();

        tbl_len = 11'd0;                           // R3 every index out of range
        va_q.push_back(va(0, 0, 12'h010));
        drain();

        tbl_len = 11'd1024;                        // whole outer table in use
        va_q.push_back(va(1023, 1023, 12'h321));
        va_q.push_back(va(0, 0, 0));
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule